// File: doc/BRIEF.md
# SPI Master Serial Engine

This block is the bit-level half of an SPI master. It takes words of 1 to 32 bits from a 32-entry transmit queue and shifts them out on the serial data line, most significant bit first. At the same time it assembles incoming bits into words and stores them in a 32-entry receive queue. The serial clock runs at the source clock divided by 2*(div+1). Consecutive words are separated by an idle stretch of 4*gap+10 source cycles. Clock polarity and the launch and capture edges are set independently.

Besides ordinary full-duplex four-wire transfers, the engine has a receive-only run. A word count is loaded, and a start strobe then produces clocks for exactly that many words, with the data output held low. In three-wire (half-duplex) mode nothing starts merely because data is queued. A transmit request strobe releases queued words, and a separate receive request strobe releases a receive-only run. In that mode the output enable is dropped while data is received. An active-low chip select follows a small select field.

The surrounding register file drives the configuration inputs and the strobes. It reads the busy flag and the word-done pulse to pace software.

Top module: `spi_serial_engine`

## Requirements
- R1: Each serial-clock half period lasts cfg_div+1 source cycles, and a word of L bits produces exactly 2L clock transitions. L is cfg_wlen, except that the value 0 means 32.
- R2: From the last clock transition of one word to the first transition of the next queued word, exactly 4*cfg_gap+10+cfg_div+1 source cycles pass.
- R3: Transmit words sit right-aligned in the queue entries and leave MSB first. With cfg_tx_neg=1, data changes on the internal falling edge and is valid at every rising edge. With cfg_tx_neg=0, data changes on the rising edges after the first one and is valid at every falling edge.
- R4: In four-wire mode, sdi is captured on the internal rising edge, or on the falling edge when cfg_rx_neg=1. Each completed word is written right-aligned into the receive queue.
- R5: The sck output equals the internal clock XOR cfg_cpol, so the idle level of sck is cfg_cpol.
- R6: A pulse on rxo_load sets the receive-only word count to rxo_words and cancels any pending run. A later rxo_start pulse in four-wire mode clocks that many words with sdo held at 0, and stores every received word. A count of 0 produces no clocks.
- R7: In three-wire mode (cfg_three_wire=1), queued transmit words wait for a tx_req pulse, and rxo_start is ignored. rx_req starts the loaded receive-only run. sdo_oe is 0 during receive words and while idle. Transmit words do not write the receive queue.
- R8: cs_n goes low the cycle after cfg_cs_sel[0]=0, goes high the cycle after cfg_cs_sel=4'hF, and otherwise holds its value.
- R9: busy is high from the start of a word until the end of the gap that follows the last word. word_done pulses for exactly one cycle, once per word, while busy is high.
- R10: Each queue holds 32 entries, and tx_full rises after 32 unread pushes. While fifo_clr is high, both queues are emptied.
- R11: After reset, cs_n=1, busy=0, word_done=0, sck=cfg_cpol, and both queues are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | 8 | Prescale value; half period is cfg_div+1 cycles |
| cfg_gap | input | 8 | Inter-word gap setting; gap is 4*cfg_gap+10 cycles |
| cfg_wlen | input | 5 | Bits per word, 0 meaning 32 |
| cfg_cpol | input | 1 | Serial clock polarity |
| cfg_tx_neg | input | 1 | Launch data on the internal falling edge |
| cfg_rx_neg | input | 1 | Capture data on the internal falling edge |
| cfg_three_wire | input | 1 | Half-duplex three-wire operation |
| cfg_cs_sel | input | 4 | Chip-select field |
| fifo_clr | input | 1 | Empties both queues while high |
| tx_push | input | 1 | Write tx_wdata into the transmit queue |
| tx_wdata | input | 32 | Transmit word, right-aligned |
| tx_full | output | 1 | Transmit queue full |
| rx_pop | input | 1 | Remove the head of the receive queue |
| rx_rdata | output | 32 | Head of the receive queue |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| rxo_load | input | 1 | Load the receive-only word count |
| rxo_words | input | 9 | Receive-only word count |
| rxo_start | input | 1 | Start receive-only run (four-wire) |
| tx_req | input | 1 | Release queued transmit words (three-wire) |
| rx_req | input | 1 | Start receive-only run (three-wire) |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the data line |
| sdi | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | Engine is shifting or in a gap |
| word_done | output | 1 | One-cycle pulse at the end of each word |

## Verification
The serial clock first changes cfg_div+1 cycles after the engine takes a word, and every later transition follows the previous one by the same amount. The exception is the first transition after a gap, which comes 4*cfg_gap+10+cfg_div+1 cycles later. The bench therefore timestamps every sck change on the falling clock edge and compares the differences against these formulas, instead of waiting fixed delays. Data bits are recorded at the same falling edge that follows each capture edge, because the engine's sdo cannot move on that edge. Queue contents, cs_n and busy are sampled at least one full cycle after the strobe that affects them, since each passes through one register.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2
  } eng_state_t;
endpackage

// File: rtl/spi_word_fifo.sv
// Synchronous queue; storage has no reset so it can map to RAM.
module spi_word_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [AW:0]      level;
  logic             do_push, do_pop;

  assign full    = (level == (AW+1)'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (do_push) wptr <= wptr + AW'(1);
      if (do_pop)  rptr <= rptr + AW'(1);
      level <= level + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end
endmodule

// File: rtl/spi_shift_core.sv
// Word sequencer, prescaler, gap timer and the two shift registers.
module spi_shift_core
  import spi_eng_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8,
  parameter int GAP_W  = 8,
  parameter int CNT_W  = 9
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [DIV_W-1:0]           cfg_div,
  input  logic [GAP_W-1:0]           cfg_gap,
  input  logic [$clog2(DATA_W)-1:0]  cfg_wlen,
  input  logic                       cfg_tx_neg,
  input  logic                       cfg_rx_neg,
  input  logic                       cfg_three_wire,
  input  logic                       tx_empty,
  input  logic [DATA_W-1:0]          tx_rdata,
  output logic                       tx_pop,
  output logic                       rx_push,
  output logic [DATA_W-1:0]          rx_wdata,
  input  logic                       rxo_load,
  input  logic [CNT_W-1:0]           rxo_words,
  input  logic                       rxo_start,
  input  logic                       tx_req,
  input  logic                       rx_req,
  input  logic                       sdi,
  output logic                       sck_int,
  output logic                       sdo,
  output logic                       sdo_oe,
  output logic                       busy,
  output logic                       word_done
);
  localparam int WL_W = $clog2(DATA_W);
  localparam int LEN_W = WL_W + 1;
  localparam int HC_W = LEN_W + 1;
  localparam int GC_W = GAP_W + 3;

  eng_state_t         state;
  logic [DIV_W-1:0]   presc, div_q;
  logic [HC_W-1:0]    hcnt;
  logic [GC_W-1:0]    gcnt, gap_len;
  logic [LEN_W-1:0]   len_q, lnew;
  logic [DATA_W-1:0]  tx_sh, rx_sh, aligned;
  logic [CNT_W-1:0]   rx_left;
  logic               rx_run, tx_arm, cur_push;
  logic               want_rx, want_tx, launch, take_rx;
  logic               half_end, rising, falling, word_last, sample, shift_out, gap_last;

  assign lnew     = (cfg_wlen == '0) ? LEN_W'(DATA_W) : {1'b0, cfg_wlen};
  assign aligned  = tx_rdata << (LEN_W'(DATA_W) - lnew);
  assign gap_len  = GC_W'({cfg_gap, 2'b00}) + GC_W'(10);
  assign gap_last = (state == ST_GAP) && (gcnt == gap_len - GC_W'(1));

  assign want_rx = rx_run && (rx_left != '0);
  assign want_tx = !tx_empty && (!cfg_three_wire || tx_arm);
  assign launch  = (want_rx || want_tx) && ((state == ST_IDLE) || gap_last);
  assign take_rx = launch && want_rx;
  assign tx_pop  = launch && !want_rx;

  assign half_end  = (state == ST_SHIFT) && (presc == div_q);
  assign rising    = half_end && !hcnt[0];
  assign falling   = half_end && hcnt[0];
  assign word_last = half_end && (hcnt == {len_q, 1'b0} - HC_W'(1));
  assign sample    = cfg_rx_neg ? falling : rising;
  assign shift_out = (cfg_tx_neg ? falling : rising) && (hcnt != '0);
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      presc     <= '0;
      div_q     <= '0;
      hcnt      <= '0;
      gcnt      <= '0;
      len_q     <= '0;
      tx_sh     <= '0;
      rx_sh     <= '0;
      sdo       <= 1'b0;
      sdo_oe    <= !cfg_three_wire;
      sck_int   <= 1'b0;
      cur_push  <= 1'b0;
      word_done <= 1'b0;
      rx_push   <= 1'b0;
      rx_wdata  <= '0;
    end else begin
      word_done <= 1'b0;
      rx_push   <= 1'b0;
      if (launch) begin
        state    <= ST_SHIFT;
        presc    <= '0;
        hcnt     <= '0;
        len_q    <= lnew;
        div_q    <= cfg_div;
        rx_sh    <= '0;
        sck_int  <= 1'b0;
        cur_push <= want_rx || !cfg_three_wire;
        tx_sh    <= want_rx ? '0 : aligned;
        sdo      <= want_rx ? 1'b0 : aligned[DATA_W-1];
        sdo_oe   <= !cfg_three_wire || !want_rx;
      end else begin
        case (state)
          ST_SHIFT: begin
            if (half_end) begin
              presc   <= '0;
              hcnt    <= hcnt + HC_W'(1);
              sck_int <= !sck_int;
            end else begin
              presc <= presc + DIV_W'(1);
            end
            if (shift_out) begin
              tx_sh <= tx_sh << 1;
              sdo   <= tx_sh[DATA_W-2];
            end
            if (sample) rx_sh <= {rx_sh[DATA_W-2:0], sdi};
            if (word_last) begin
              state     <= ST_GAP;
              gcnt      <= '0;
              word_done <= 1'b1;
              rx_push   <= cur_push;
              rx_wdata  <= sample ? {rx_sh[DATA_W-2:0], sdi} : rx_sh;
            end
          end
          ST_GAP: begin
            gcnt <= gcnt + GC_W'(1);
            if (gap_last) begin
              state  <= ST_IDLE;
              sdo    <= 1'b0;
              sdo_oe <= !cfg_three_wire;
            end
          end
          default: begin
            sdo    <= 1'b0;
            sdo_oe <= !cfg_three_wire;
          end
        endcase
      end
    end
  end

  // Receive-only word budget and three-wire transmit release.
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_left <= '0;
      rx_run  <= 1'b0;
      tx_arm  <= 1'b0;
    end else begin
      if (rxo_load) begin
        rx_left <= rxo_words;
        rx_run  <= 1'b0;
      end else begin
        if (take_rx) begin
          rx_left <= rx_left - CNT_W'(1);
          if (rx_left == CNT_W'(1)) rx_run <= 1'b0;
        end else if (rx_run && rx_left == '0) begin
          rx_run <= 1'b0;
        end
        if ((rxo_start && !cfg_three_wire) || (rx_req && cfg_three_wire)) rx_run <= 1'b1;
      end
      if (!cfg_three_wire)                  tx_arm <= 1'b0;
      else if (tx_req)                      tx_arm <= 1'b1;
      else if (tx_empty && state == ST_IDLE) tx_arm <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_serial_engine.sv
module spi_serial_engine #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  parameter int DIV_W  = 8,
  parameter int GAP_W  = 8,
  parameter int CNT_W  = 9
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [DIV_W-1:0]           cfg_div,
  input  logic [GAP_W-1:0]           cfg_gap,
  input  logic [$clog2(DATA_W)-1:0]  cfg_wlen,
  input  logic                       cfg_cpol,
  input  logic                       cfg_tx_neg,
  input  logic                       cfg_rx_neg,
  input  logic                       cfg_three_wire,
  input  logic [3:0]                 cfg_cs_sel,
  input  logic                       fifo_clr,
  input  logic                       tx_push,
  input  logic [DATA_W-1:0]          tx_wdata,
  output logic                       tx_full,
  input  logic                       rx_pop,
  output logic [DATA_W-1:0]          rx_rdata,
  output logic                       rx_empty,
  output logic                       rx_full,
  input  logic                       rxo_load,
  input  logic [CNT_W-1:0]           rxo_words,
  input  logic                       rxo_start,
  input  logic                       tx_req,
  input  logic                       rx_req,
  output logic                       sck,
  output logic                       sdo,
  output logic                       sdo_oe,
  input  logic                       sdi,
  output logic                       cs_n,
  output logic                       busy,
  output logic                       word_done
);
  logic              tx_empty, tx_pop, rx_push, sck_int;
  logic [DATA_W-1:0] tx_rdata, rx_wdata;

  spi_word_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .clr(fifo_clr),
    .push(tx_push), .din(tx_wdata), .pop(tx_pop), .dout(tx_rdata),
    .full(tx_full), .empty(tx_empty)
  );

  spi_word_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .clr(fifo_clr),
    .push(rx_push), .din(rx_wdata), .pop(rx_pop), .dout(rx_rdata),
    .full(rx_full), .empty(rx_empty)
  );

  spi_shift_core #(.DATA_W(DATA_W), .DIV_W(DIV_W), .GAP_W(GAP_W), .CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst),
    .cfg_div(cfg_div), .cfg_gap(cfg_gap), .cfg_wlen(cfg_wlen),
    .cfg_tx_neg(cfg_tx_neg), .cfg_rx_neg(cfg_rx_neg), .cfg_three_wire(cfg_three_wire),
    .tx_empty(tx_empty), .tx_rdata(tx_rdata), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_wdata(rx_wdata),
    .rxo_load(rxo_load), .rxo_words(rxo_words), .rxo_start(rxo_start),
    .tx_req(tx_req), .rx_req(rx_req), .sdi(sdi),
    .sck_int(sck_int), .sdo(sdo), .sdo_oe(sdo_oe),
    .busy(busy), .word_done(word_done)
  );

  assign sck = sck_int ^ cfg_cpol;

  // Chip select: bit 0 clear asserts, all ones releases, anything else holds.
  always_ff @(posedge clk) begin
    if (rst)                     cs_n <= 1'b1;
    else if (!cfg_cs_sel[0])     cs_n <= 1'b0;
    else if (cfg_cs_sel == 4'hF) cs_n <= 1'b1;
  end
endmodule

// File: rtl/spi_serial_engine_chk.sv
module spi_serial_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic       sck,
  input logic       cfg_cpol,
  input logic       busy,
  input logic       word_done,
  input logic [3:0] cfg_cs_sel,
  input logic       cs_n,
  input logic       cfg_three_wire,
  input logic       sdo_oe
);
  assert_idle_level_R5: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (sck == cfg_cpol));

  assert_done_in_busy_R9: assert property (@(posedge clk) disable iff (rst)
    word_done |-> busy);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    word_done |=> !word_done);

  assert_cs_assert_R8: assert property (@(posedge clk) disable iff (rst)
    !cfg_cs_sel[0] |=> !cs_n);

  assert_cs_release_R8: assert property (@(posedge clk) disable iff (rst)
    (cfg_cs_sel == 4'hF) |=> cs_n);

  assert_idle_oe_R7: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && $stable(cfg_three_wire)) |-> (sdo_oe == !cfg_three_wire));
endmodule

bind spi_serial_engine spi_serial_engine_chk u_chk (
  .clk(clk), .rst(rst), .sck(sck), .cfg_cpol(cfg_cpol), .busy(busy),
  .word_done(word_done), .cfg_cs_sel(cfg_cs_sel), .cs_n(cs_n),
  .cfg_three_wire(cfg_three_wire), .sdo_oe(sdo_oe)
);

// File: tb/spi_serial_engine_test.sv
module spi_serial_engine_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cfg_div = '0, cfg_gap = '0;
  logic [4:0]  cfg_wlen = 5'd8;
  logic        cfg_cpol = 0, cfg_tx_neg = 1, cfg_rx_neg = 0, cfg_three_wire = 0;
  logic [3:0]  cfg_cs_sel = 4'hF;
  logic        fifo_clr = 0, tx_push = 0, rx_pop = 0, rxo_load = 0, rxo_start = 0;
  logic        tx_req = 0, rx_req = 0;
  logic [31:0] tx_wdata = '0;
  logic [8:0]  rxo_words = '0;
  logic        tx_full, rx_empty, rx_full, sck, sdo, sdo_oe, sdi, cs_n, busy, word_done;
  logic [31:0] rx_rdata;

  always #2 clk = ~clk;

  spi_serial_engine uut (
    .clk(clk), .rst(rst), .cfg_div(cfg_div), .cfg_gap(cfg_gap), .cfg_wlen(cfg_wlen),
    .cfg_cpol(cfg_cpol), .cfg_tx_neg(cfg_tx_neg), .cfg_rx_neg(cfg_rx_neg),
    .cfg_three_wire(cfg_three_wire), .cfg_cs_sel(cfg_cs_sel), .fifo_clr(fifo_clr),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_full(tx_full), .rx_pop(rx_pop),
    .rx_rdata(rx_rdata), .rx_empty(rx_empty), .rx_full(rx_full), .rxo_load(rxo_load),
    .rxo_words(rxo_words), .rxo_start(rxo_start), .tx_req(tx_req), .rx_req(rx_req),
    .sck(sck), .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi), .cs_n(cs_n), .busy(busy),
    .word_done(word_done)
  );

  int errors = 0;
  int checks = 0;
  longint cyc = 0;
  always @(posedge clk) cyc++;

  // Bench-side slave and line monitor.
  logic [31:0] txw [0:7];
  logic [31:0] slave_w [0:7];
  longint ts [0:255];
  logic sbits [0:255];
  logic soe [0:255];
  int ntr = 0, sc = 0, ndone = 0, cur_len = 8;
  logic prev_sck = 1'b0;

  assign sdi = (cur_len == 0) ? 1'b0 :
               slave_w[(sc / cur_len) % 8][cur_len - 1 - (sc % cur_len)];

  always @(negedge clk) begin
    if (!rst) begin
      if (sck !== prev_sck) begin
        if (ntr < 256) ts[ntr] = cyc;
        ntr++;
        if (((sck ^ cfg_cpol) == 1'b1) != cfg_rx_neg) begin
          if (sc < 256) begin
            sbits[sc] = sdo;
            soe[sc] = sdo_oe;
          end
          sc++;
        end
      end
      if (word_done) ndone++;
      prev_sck = sck;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lmask(input int l);
    return (l >= 32) ? 32'hFFFF_FFFF : ((32'h1 << l) - 32'h1);
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic pulse(ref logic s);
    tick(); s = 1'b1; tick(); s = 1'b0;
  endtask

  task automatic push_word(input logic [31:0] d);
    tick(); tx_push = 1'b1; tx_wdata = d; tick(); tx_push = 1'b0;
  endtask

  task automatic pop_word(output logic [31:0] d);
    tick(); d = rx_rdata; rx_pop = 1'b1; tick(); rx_pop = 1'b0;
  endtask

  task automatic wait_idle();
    int g = 0;
    repeat (4) @(negedge clk);
    while (busy && g < 50000) begin @(negedge clk); g++; end
    if (busy) chk(0, "R9 engine never went idle", 1, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic setup(input int wl, input int dv, input int gp, input bit pol,
                       input bit ph, input bit three);
    tick();
    cfg_wlen = 5'(wl % 32); cfg_div = 8'(dv); cfg_gap = 8'(gp); cfg_cpol = pol;
    cfg_tx_neg = !ph; cfg_rx_neg = ph; cfg_three_wire = three;
    cur_len = wl;
    for (int i = 0; i < 8; i++) begin
      txw[i] = $urandom() & lmask(wl);
      slave_w[i] = $urandom();
    end
    tick(); tick();
    ntr = 0; sc = 0; ndone = 0; prev_sck = sck;
    @(negedge clk);
    chk(sck === pol, "R5 idle sck level", sck, pol);
  endtask

  // Compares everything the monitor saw against the requirement formulas.
  task automatic verify(input int nw, input int L, input int dv, input int gp,
                        input bit is_tx, input bit expect_rx, input bit oe_exp, input string tag);
    int bad_half = 0, bad_gap = 0, bad_bit = 0, bad_oe = 0;
    logic [31:0] d;
    chk(ntr == 2 * L * nw, {"R1 transition count ", tag}, ntr, 2 * L * nw);
    for (int t = 1; t < ntr && t < 256; t++) begin
      if (t % (2 * L) == 0) begin
        if (ts[t] - ts[t-1] != 4 * gp + 10 + dv + 1) bad_gap++;
      end else if (ts[t] - ts[t-1] != dv + 1) bad_half++;
    end
    chk(bad_half == 0, {"R1 half period ", tag}, bad_half, 0);
    if (nw > 1) chk(bad_gap == 0, {"R2 inter-word gap ", tag}, bad_gap, 0);
    for (int s = 0; s < sc && s < 256; s++) begin
      logic eb;
      eb = is_tx ? txw[s / L][L - 1 - (s % L)] : 1'b0;
      if (sbits[s] !== eb) bad_bit++;
      if (soe[s] !== oe_exp) bad_oe++;
    end
    chk(bad_bit == 0, {is_tx ? "R3 sdo bits " : "R6 sdo held low ", tag}, bad_bit, 0);
    chk(bad_oe == 0, {"R7 sdo_oe during words ", tag}, bad_oe, 0);
    chk(ndone == nw, {"R9 word_done count ", tag}, ndone, nw);
    if (expect_rx) begin
      for (int w = 0; w < nw; w++) begin
        pop_word(d);
        chk(d === (slave_w[w] & lmask(L)), {"R4 received word ", tag}, d, slave_w[w] & lmask(L));
      end
    end
    @(negedge clk);
    chk(rx_empty === 1'b1, {"R4 receive queue drained ", tag}, rx_empty, 1);
  endtask

  task automatic run_tx(input int nw, input int wl, input int dv, input int gp,
                        input bit pol, input bit ph, input string tag);
    setup(wl, dv, gp, pol, ph, 1'b0);
    for (int w = 0; w < nw; w++) push_word(txw[w] | (~lmask(wl) & 32'hA5A5_A5A5));
    wait_idle();
    verify(nw, wl, dv, gp, 1'b1, 1'b1, 1'b1, tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) tick();
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(cs_n === 1'b1, "R11 cs_n after reset", cs_n, 1);
    chk(busy === 1'b0, "R11 busy after reset", busy, 0);
    chk(word_done === 1'b0, "R11 word_done after reset", word_done, 0);
    chk(sck === 1'b0, "R11 sck after reset", sck, 0);
    chk(rx_empty === 1'b1 && tx_full === 1'b0, "R11 queues after reset", {rx_empty, tx_full}, 2'b10);

    // Directed full-duplex runs, including 32-bit and 1-bit words (R1 R2 R3 R4 R5)
    run_tx(2, 8, 1, 1, 1'b0, 1'b0, "d8");
    run_tx(1, 32, 0, 0, 1'b1, 1'b1, "d32");
    run_tx(3, 1, 0, 0, 1'b0, 1'b1, "d1");
    run_tx(2, 13, 3, 2, 1'b1, 1'b0, "d13");

    // Constrained random full-duplex runs
    for (int it = 0; it < 8; it++) begin
      run_tx(1 + int'($urandom_range(2)), 1 + int'($urandom_range(31)),
             int'($urandom_range(3)), int'($urandom_range(3)),
             1'($urandom_range(1)), 1'($urandom_range(1)), "rnd");
    end

    // R6 receive-only run in four-wire mode
    setup(12, 1, 2, 1'b0, 1'b0, 1'b0);
    tick(); rxo_words = 9'd3; pulse(rxo_load); pulse(rxo_start);
    wait_idle();
    verify(3, 12, 1, 2, 1'b0, 1'b1, 1'b1, "rxo");
    // R6 a zero count generates no clocks
    setup(12, 1, 2, 1'b0, 1'b0, 1'b0);
    tick(); rxo_words = 9'd0; pulse(rxo_load); pulse(rxo_start);
    repeat (30) @(negedge clk);
    chk(ntr == 0 && busy === 1'b0, "R6 zero count is idle", ntr, 0);

    // R7 three-wire transmit waits for tx_req and writes nothing into the receive queue
    setup(6, 0, 1, 1'b0, 1'b0, 1'b1);
    push_word(txw[0]); push_word(txw[1]);
    repeat (40) @(negedge clk);
    chk(busy === 1'b0 && ntr == 0, "R7 no start without tx_req", ntr, 0);
    pulse(tx_req);
    wait_idle();
    verify(2, 6, 0, 1, 1'b1, 1'b0, 1'b1, "3w-tx");

    // R7 three-wire receive ignores rxo_start and runs on rx_req with output disabled
    setup(9, 1, 0, 1'b1, 1'b1, 1'b1);
    tick(); rxo_words = 9'd2; pulse(rxo_load); pulse(rxo_start);
    repeat (40) @(negedge clk);
    chk(busy === 1'b0 && ntr == 0, "R7 rxo_start ignored in three-wire", ntr, 0);
    pulse(rx_req);
    wait_idle();
    verify(2, 9, 1, 0, 1'b0, 1'b1, 1'b0, "3w-rx");
    @(negedge clk);
    chk(sdo_oe === 1'b0, "R7 sdo_oe low while idle", sdo_oe, 0);

    // R8 chip select field decoding
    tick(); cfg_cs_sel = 4'b1110; tick(); @(negedge clk);
    chk(cs_n === 1'b0, "R8 cs asserts on bit0 clear", cs_n, 0);
    tick(); cfg_cs_sel = 4'b0011; tick(); tick(); @(negedge clk);
    chk(cs_n === 1'b0, "R8 cs holds on partial field", cs_n, 0);
    tick(); cfg_cs_sel = 4'hF; tick(); @(negedge clk);
    chk(cs_n === 1'b1, "R8 cs releases on all ones", cs_n, 1);

    // R10 queue depth and clear (three-wire so nothing drains)
    setup(8, 0, 0, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 31; i++) push_word(32'(i));
    @(negedge clk);
    chk(tx_full === 1'b0, "R10 not full at 31", tx_full, 0);
    push_word(32'h55);
    @(negedge clk);
    chk(tx_full === 1'b1, "R10 full at 32", tx_full, 1);
    pulse(fifo_clr);
    @(negedge clk);
    chk(tx_full === 1'b0, "R10 clear empties transmit queue", tx_full, 0);
    pulse(tx_req);
    repeat (30) @(negedge clk);
    chk(busy === 1'b0 && ntr == 0, "R10 cleared queue sends nothing", ntr, 0);
    setup(8, 0, 0, 1'b0, 1'b0, 1'b0);
    tick(); rxo_words = 9'd2; pulse(rxo_load); pulse(rxo_start);
    wait_idle();
    chk(rx_empty === 1'b0, "R10 receive queue filled", rx_empty, 0);
    pulse(fifo_clr);
    @(negedge clk);
    chk(rx_empty === 1'b1, "R10 clear empties receive queue", rx_empty, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R9 watchdog expired actual=%0d expected<%0d", cyc, 200000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule